// File: doc/BRIEF.md
# One-Time Programmable Configuration Store

This block emulates a small fuse-style configuration store with flip-flops. It holds 768 bytes (6144 bits) that start at zero and can only gain ones. Every accepted write merges the new byte into the stored byte with a bitwise OR, so a bit that has been set stays set. Software programs the store in one of two ways. It can issue single-byte program cycles, any number of them to the same byte. It can also start a sweep that takes a byte stream and fills every address in order.

Writes are gated by an enable key register and refused while the block is busy. After every warm reset the block streams its whole contents to a configuration consumer in address order and then raises a done level. A separate blanking reset stands in for a fresh, unprogrammed part. The warm reset leaves the stored bits alone.

Top module: `otp_store`

## Requirements
- R1: After the blanking reset `por_n`, every byte reads as 0x00 through the read port and through the load stream.
- R2: An accepted program cycle stores `old | prog_data` at `prog_addr`, so no bit ever returns from 1 to 0. `wr_ack` pulses in the cycle after the request.
- R3: `mismatch` pulses together with `wr_ack` when the written data has a 0 in a position where the stored byte already holds a 1.
- R4: Unless the key register, loaded through `key_wr`/`key_data`, holds 16'hC3A5, a program request or sweep start is dropped and `err_key` pulses. A warm reset clears the key register to zero.
- R5: A read at address 768 or above returns 0x00. A program request at address 768 or above changes nothing and pulses `err_range`.
- R6: From the first clock edge after `rst_n` is released, the block emits 768 consecutive `ld_valid` cycles carrying addresses 0 to 767 with their stored bytes. On the next edge `ld_valid` falls and `ld_done` rises, and `ld_done` then holds until the next reset.
- R7: While `busy` is high (load stream or sweep in progress), a program request changes nothing and pulses `err_busy`.
- R8: An accepted `sweep_start` raises `busy` from the next edge. Each `sweep_valid` byte is ORed into the next address, starting at 0 and acknowledged by `wr_ack`. After the byte for address 767, `busy` falls. A `sweep_start` in the same cycle as `prog_req` is ignored, and the program request is served.
- R9: The stored contents survive a warm reset (`rst_n` alone) and are what the following load stream carries.
- R10: At most one error bit pulses per request, in the priority busy, then key, then range.
- R11: `sweep_valid` outside a sweep writes nothing and produces no `wr_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low blanking reset, clears the array |
| rst_n | input | 1 | Active-low warm reset, restarts the load stream and clears the key |
| key_wr | input | 1 | Load key register |
| key_data | input | 16 | Value for the key register |
| prog_req | input | 1 | Single-byte program request |
| prog_addr | input | 10 | Byte address of the program request |
| prog_data | input | 8 | Bits to set |
| sweep_start | input | 1 | Start a whole-array sweep |
| sweep_valid | input | 1 | Sweep byte present |
| sweep_data | input | 8 | Sweep byte |
| rd_addr | input | 10 | Read address |
| rd_data | output | 8 | Read data, one cycle after the address |
| ld_valid | output | 1 | Load stream byte valid |
| ld_addr | output | 10 | Load stream address |
| ld_data | output | 8 | Load stream byte |
| ld_done | output | 1 | Load stream finished |
| busy | output | 1 | Load stream or sweep in progress |
| wr_ack | output | 1 | A byte write was performed |
| mismatch | output | 1 | The written byte tried to clear a set bit |
| err_key | output | 1 | Request dropped, key not valid |
| err_range | output | 1 | Request dropped, address out of range |
| err_busy | output | 1 | Request dropped, block busy |

## Verification
The status pulses (`wr_ack`, `mismatch`, the three error bits) and `rd_data` are registered once, so each is due on the edge right after the request or address edge. The bench drives inputs on the falling edge and samples at the next falling edge. The load stream puts address k on the (k+1)-th edge after reset release, so the bench steps one falling edge per byte from release and expects `ld_done` one edge after the last byte. `busy` follows the edge that starts or ends a sweep, so it is sampled at the falling edge after that edge. A stored byte can be read back at the earliest with an address presented after the write edge.

// File: rtl/otp_store.sv
module otp_store #(
  parameter int N_BYTES = 768,
  parameter int AW = 10,
  parameter int DW = 8,
  parameter int KW = 16,
  parameter logic [KW-1:0] KEY_MAGIC = 16'hC3A5
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic [KW-1:0] key_data,
  input  logic          prog_req,
  input  logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  input  logic          sweep_start,
  input  logic          sweep_valid,
  input  logic [DW-1:0] sweep_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          ld_valid,
  output logic [AW-1:0] ld_addr,
  output logic [DW-1:0] ld_data,
  output logic          ld_done,
  output logic          busy,
  output logic          wr_ack,
  output logic          mismatch,
  output logic          err_key,
  output logic          err_range,
  output logic          err_busy
);
  localparam logic [AW-1:0] LAST = AW'(N_BYTES - 1);

  logic [DW-1:0] mem [N_BYTES];
  logic [KW-1:0] key_q;
  logic          ro_active, sw_active;
  logic [AW-1:0] ro_cnt, sw_ptr;

  wire key_ok   = key_q == KEY_MAGIC;
  wire p_inr    = int'(prog_addr) < N_BYTES;
  wire r_inr    = int'(rd_addr) < N_BYTES;
  assign busy   = ro_active | sw_active;

  wire p_busy   = prog_req & busy;
  wire p_key    = prog_req & ~busy & ~key_ok;
  wire p_rng    = prog_req & ~busy & key_ok & ~p_inr;
  wire p_go     = prog_req & ~busy & key_ok & p_inr;

  wire s_req    = sweep_start & ~prog_req;
  wire s_busy   = s_req & busy;
  wire s_key    = s_req & ~busy & ~key_ok;
  wire s_go     = s_req & ~busy & key_ok;
  wire s_wr     = sw_active & sweep_valid;

  wire           we   = p_go | s_wr;
  wire [AW-1:0]  wa   = s_wr ? sw_ptr : (p_inr ? prog_addr : '0);
  wire [DW-1:0]  wd   = s_wr ? sweep_data : prog_data;
  wire [DW-1:0]  old  = mem[wa];
  wire [AW-1:0]  ridx = r_inr ? rd_addr : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < N_BYTES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= old | wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else if (key_wr) key_q <= key_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ro_active <= 1'b1;
      ro_cnt    <= '0;
      ld_valid  <= 1'b0;
      ld_addr   <= '0;
      ld_data   <= '0;
      ld_done   <= 1'b0;
    end else if (ro_active) begin
      ld_valid <= 1'b1;
      ld_addr  <= ro_cnt;
      ld_data  <= mem[ro_cnt];
      if (ro_cnt == LAST) ro_active <= 1'b0;
      else ro_cnt <= ro_cnt + 1'b1;
    end else begin
      ld_valid <= 1'b0;
      ld_done  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_active <= 1'b0;
      sw_ptr    <= '0;
    end else if (s_go) begin
      sw_active <= 1'b1;
      sw_ptr    <= '0;
    end else if (s_wr) begin
      if (sw_ptr == LAST) sw_active <= 1'b0;
      else sw_ptr <= sw_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      wr_ack    <= 1'b0;
      mismatch  <= 1'b0;
      err_key   <= 1'b0;
      err_range <= 1'b0;
      err_busy  <= 1'b0;
    end else begin
      rd_data   <= r_inr ? mem[ridx] : '0;
      wr_ack    <= we;
      mismatch  <= we & |(old & ~wd);
      err_key   <= p_key | s_key;
      err_range <= p_rng;
      err_busy  <= p_busy | s_busy;
    end
  end
endmodule

module otp_store_chk #(
  parameter int AW = 10,
  parameter int KW = 16,
  parameter logic [KW-1:0] KEY_MAGIC = 16'hC3A5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prog_req,
  input logic          busy,
  input logic [KW-1:0] key_q,
  input logic          ld_valid,
  input logic [AW-1:0] ld_addr,
  input logic          ld_done,
  input logic          wr_ack,
  input logic          mismatch,
  input logic          err_key,
  input logic          err_range,
  input logic          err_busy
);
  // R6
  ld_done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) ld_done |=> ld_done);
  // R6
  ld_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ld_valid && ld_done));
  // R6
  ld_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && $past(ld_valid) |-> ld_addr == AW'($past(ld_addr) + 1'b1));
  // R10
  err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({err_busy, err_key, err_range}));
  // R3
  mismatch_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) mismatch |-> wr_ack);
  // R7
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n) prog_req && busy |=> err_busy);
  // R4
  key_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req && !busy && key_q != KEY_MAGIC |=> err_key && !wr_ack);
endmodule

bind otp_store otp_store_chk #(.AW(AW), .KW(KW), .KEY_MAGIC(KEY_MAGIC)) chk_i (
  .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .busy(busy), .key_q(key_q),
  .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_done(ld_done), .wr_ack(wr_ack),
  .mismatch(mismatch), .err_key(err_key), .err_range(err_range), .err_busy(err_busy)
);

// File: tb/otp_store_tb.sv
module otp_store_tb_top;
  localparam int CLK_P = 10;
  localparam int NB = 768;
  localparam logic [15:0] MAGIC = 16'hC3A5;

  logic clk = 1'b0;
  logic por_n, rst_n, key_wr, prog_req, sweep_start, sweep_valid;
  logic [15:0] key_data;
  logic [9:0] prog_addr, rd_addr, ld_addr;
  logic [7:0] prog_data, sweep_data, rd_data, ld_data;
  logic ld_valid, ld_done, busy, wr_ack, mismatch, err_key, err_range, err_busy;

  logic [7:0] model [NB];
  logic [15:0] bkey;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  otp_store dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .key_wr(key_wr), .key_data(key_data),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .sweep_start(sweep_start), .sweep_valid(sweep_valid), .sweep_data(sweep_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_data(ld_data), .ld_done(ld_done), .busy(busy), .wr_ack(wr_ack),
    .mismatch(mismatch), .err_key(err_key), .err_range(err_range), .err_busy(err_busy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sweep_byte(input int i);
    return 8'((i * 37) ^ 8'h5A);
  endfunction

  task automatic set_key(input logic [15:0] k);
    key_wr = 1'b1; key_data = k;
    @(negedge clk);
    key_wr = 1'b0; bkey = k;
  endtask

  task automatic do_prog(input int a, input logic [7:0] d, input string req);
    bit kok = (bkey == MAGIC);
    bit inr = (a < NB);
    bit ack = kok && inr;
    bit mm  = ack && ((model[inr ? a : 0] & ~d) != 8'h00);
    prog_req = 1'b1; prog_addr = 10'(a); prog_data = d;
    @(negedge clk);
    prog_req = 1'b0;
    chk(req, "wr_ack", int'(wr_ack), int'(ack));
    chk(req, "mismatch", int'(mismatch), int'(mm));
    chk(req, "err_key", int'(err_key), int'(!kok));
    chk(req, "err_range", int'(err_range), int'(kok && !inr));
    if (ack) model[a] = model[a] | d;
  endtask

  task automatic do_rd(input int a, input string req);
    rd_addr = 10'(a);
    @(negedge clk);
    chk(req, $sformatf("rd_data @%0d", a), int'(rd_data), (a < NB) ? int'(model[a]) : 0);
  endtask

  task automatic readout(input string req, input bit poke_busy);
    int bad = 0;
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      if (!(ld_valid && ld_addr == 10'(i) && ld_data == model[i])) begin
        if (bad == 0) chk(req, $sformatf("load byte %0d addr/data", i),
                          int'({ld_valid, ld_addr, ld_data}), int'({1'b1, 10'(i), model[i]}));
        bad++;
      end
      if (poke_busy && i == 1) begin key_wr = 1'b1; key_data = MAGIC; end
      if (poke_busy && i == 2) begin key_wr = 1'b0; bkey = MAGIC; end
      if (poke_busy && i == 5) begin prog_req = 1'b1; prog_addr = 10'd3; prog_data = 8'hFF; end
      if (poke_busy && i == 6) begin
        prog_req = 1'b0;
        // R7 R10: busy wins over a valid key
        chk("R7", "err_busy during load", int'(err_busy), 1);
        chk("R10", "err_key during load", int'(err_key), 0);
        chk("R7", "wr_ack during load", int'(wr_ack), 0);
      end
    end
    chk(req, "load stream bad bytes", bad, 0);
    @(negedge clk);
    chk("R6", "ld_valid after stream", int'(ld_valid), 0);
    chk("R6", "ld_done after stream", int'(ld_done), 1);
    chk("R6", "busy after stream", int'(busy), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0751_2024));
    por_n = 0; rst_n = 0; key_wr = 0; key_data = 0; prog_req = 0; prog_addr = 0;
    prog_data = 0; sweep_start = 0; sweep_valid = 0; sweep_data = 0; rd_addr = 0;
    bkey = 16'h0;
    for (int i = 0; i < NB; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R6", "reset ld_valid", int'(ld_valid), 0);
    chk("R6", "reset ld_done", int'(ld_done), 0);
    chk("R2", "reset wr_ack", int'(wr_ack), 0);
    chk("R10", "reset errors", int'({err_key, err_range, err_busy}), 0);
    por_n = 1; rst_n = 1;

    // R1 R6 R7: blank stream after power-on
    readout("R1", 1'b1);
    do_rd(0, "R1"); do_rd(767, "R1"); do_rd(400, "R1");

    // R2 R3: successive OR writes to one byte
    do_prog(10, 8'hF0, "R2");
    do_prog(10, 8'h0F, "R3");
    do_rd(10, "R2");
    chk("R2", "byte 10 merged", int'(model[10]), 8'hFF);
    do_prog(10, 8'h00, "R3");
    do_rd(10, "R2");

    // R5 R10: range and priority
    do_rd(768, "R5"); do_rd(1023, "R5");
    do_prog(800, 8'hAA, "R5");
    set_key(16'h1234);
    do_prog(900, 8'hAA, "R10");
    do_prog(11, 8'h55, "R4");
    do_rd(11, "R4");
    set_key(MAGIC);

    // R2 R3 R4 R5: random program cycles
    for (int n = 0; n < 250; n++) begin
      int a;
      logic [7:0] d;
      if ($urandom % 10 == 0) set_key(16'(($urandom % 16'hFFFF) ^ MAGIC) | 16'h0001 ? 16'h0BAD : 16'h0BAD);
      else if (bkey != MAGIC) set_key(MAGIC);
      a = ($urandom % 8 == 0) ? NB + int'($urandom % 256) : int'($urandom % NB);
      d = 8'($urandom);
      do_prog(a, d, "R2");
      if (a < NB) do_rd(a, "R2");
    end

    // R8: sweep
    set_key(MAGIC);
    sweep_start = 1'b1;
    @(negedge clk);
    sweep_start = 1'b0;
    chk("R8", "busy after sweep start", int'(busy), 1);
    prog_req = 1'b1; prog_addr = 10'd3; prog_data = 8'hFF;
    @(negedge clk);
    prog_req = 1'b0;
    chk("R7", "err_busy during sweep", int'(err_busy), 1);
    chk("R7", "wr_ack during sweep", int'(wr_ack), 0);
    begin
      int bad = 0;
      for (int i = 0; i < NB; i++) begin
        if ($urandom % 4 == 0) begin
          sweep_valid = 1'b0;
          @(negedge clk);
        end
        sweep_valid = 1'b1; sweep_data = sweep_byte(i);
        @(negedge clk);
        if (!wr_ack) bad++;
        model[i] = model[i] | sweep_byte(i);
      end
      sweep_valid = 1'b0;
      chk("R8", "sweep acks missing", bad, 0);
    end
    chk("R8", "busy after last sweep byte", int'(busy), 0);
    do_rd(0, "R8"); do_rd(1, "R8"); do_rd(383, "R8"); do_rd(767, "R8");

    // R11: stray sweep byte
    sweep_valid = 1'b1; sweep_data = 8'hFF;
    @(negedge clk);
    sweep_valid = 1'b0;
    chk("R11", "wr_ack on stray sweep byte", int'(wr_ack), 0);
    do_rd(0, "R11");

    // R4: sweep with bad key
    set_key(16'h0000);
    sweep_start = 1'b1;
    @(negedge clk);
    sweep_start = 1'b0;
    chk("R4", "err_key on sweep start", int'(err_key), 1);
    chk("R4", "busy after refused sweep", int'(busy), 0);

    // R8: sweep start together with a program request
    set_key(MAGIC);
    sweep_start = 1'b1;
    do_prog(20, 8'h01, "R8");
    sweep_start = 1'b0;
    chk("R8", "busy after simultaneous start", int'(busy), 0);
    do_rd(20, "R8");

    // R9: warm reset keeps contents, clears key
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    bkey = 16'h0;
    readout("R9", 1'b0);
    do_prog(30, 8'h80, "R4");
    do_rd(30, "R9");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule